// File: doc/BRIEF.md
# Memory lock-bit guard

This block keeps the one-byte lock word of a microcontroller whose program flash is split into an application section and a boot loader section. Every cycle it answers a set of permission questions from that word: may an external programmer write or verify the memory, may the fuses be rewritten, may the debug port be switched on, may a self-programming write reach a given section, may a program-memory read cross from one section into the other, and may an interrupt be taken. All answers are combinational from the registered lock word and the current request context. The context is the executing section, the target section and where the vector table sits.

Lock bits use inverted sense: 1 is open and 0 is set. A program command can only clear bits, because the stored word is ANDed with the request. Only an erase command returns the word to all ones. A status FSM in the lock store follows the word and has two states, `ST_ERASED` and `ST_PROGRAMMED`. The transition ERASED→PROGRAMMED happens on a program command that clears any active bit. The transition PROGRAMMED→ERASED happens on an erase command. In every other case the state holds. The block also raises a bypass flag when the debug enable fuse is on while any lock bit is set, because the debug path can still read the memory in that case.

Top module: `lockbit_guard`

## Requirements
- R1: `lock_byte[7:6]` always reads 2'b11. The active bits are: bit 0 external-write seal, bit 1 external-read seal, bit 2 application write guard, bit 3 application cross-read guard, bit 4 boot write guard, bit 5 boot cross-read guard. A value of 0 means the bit is set.
- R2: After reset, `lock_byte` is 8'hFF.
- R3: A program command (`prog_cmd`=1, `erase_cmd`=0) makes the next-cycle word `lock_byte & (prog_data | 8'hC0)`. A 1 in `prog_data` never restores a cleared bit. The word is unchanged in the cycle of the command.
- R4: An erase command makes `lock_byte` 8'hFF on the next cycle. Erase wins over a program command in the same cycle.
- R5: `ext_prog_ok`, `fuse_write_ok` and `dbg_ok` are 1 only when bits 1:0 are 2'b11.
- R6: `ext_verify_ok` equals bit 1. Codes 11 and 10 allow verification. The code 01 is treated like 00, so both deny it.
- R7: `spm_ok` is bit 2 when `tgt_sect`=0 (application) and bit 4 when `tgt_sect`=1 (boot). The executing section does not affect it.
- R8: `lpm_ok` is 1 when `exec_sect` equals `tgt_sect`. A read of the application section from boot code equals bit 3. A read of the boot section from application code equals bit 5.
- R9: With `vec_in_boot`=1 and `exec_sect`=0, `irq_ok` equals bit 3. With `vec_in_boot`=0 and `exec_sect`=1, `irq_ok` equals bit 5. In every other case `irq_ok` is 1.
- R10: `dbg_bypass` is 1 exactly when `dbg_fuse_en`=1 and at least one of bits 5:0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| erase_cmd | input | 1 | Chip erase: return lock word to all ones |
| prog_cmd | input | 1 | Program lock word (AND with `prog_data`) |
| prog_data | input | 8 | Requested lock word |
| exec_sect | input | 1 | Section holding the running code (0 app, 1 boot) |
| tgt_sect | input | 1 | Section addressed by the access (0 app, 1 boot) |
| vec_in_boot | input | 1 | Vector table placed in the boot section |
| dbg_fuse_en | input | 1 | Debug enable fuse state |
| lock_byte | output | 8 | Current lock word |
| ext_prog_ok | output | 1 | External programming allowed |
| ext_verify_ok | output | 1 | External verification allowed |
| fuse_write_ok | output | 1 | Fuse rewrite allowed |
| dbg_ok | output | 1 | Debug port may be enabled |
| spm_ok | output | 1 | Self-programming write to target allowed |
| lpm_ok | output | 1 | Code read of target allowed |
| irq_ok | output | 1 | Interrupts allowed in current context |
| dbg_bypass | output | 1 | Debug read-out bypasses set lock bits |

## Verification
A corrupted lock word shows up at `lock_byte` one cycle after the faulty command. The grant outputs show it in that same cycle, because they decode the stored word with no extra register. A bit that comes back to 1 without an erase is the most serious fault. It appears as a rising bit in `lock_byte` and as a grant that returns after it was denied. Both are caught on the first cycle after the update. A decode fault in a section policy leaves the word correct but flips a grant. It therefore shows only when the bench sets the matching lock code, section pair and vector placement.

// File: rtl/lockbit_pkg.sv
package lockbit_pkg;
    localparam int LOCK_W  = 8;
    localparam int NSECT   = 2;
    localparam int ACTIVE  = 6;
    localparam logic [LOCK_W-1:0] ERASED_WORD = '1;
    localparam logic [LOCK_W-1:0] PAD_MASK    = ~((LOCK_W)'((1 << ACTIVE) - 1));

    typedef enum logic {
        ST_ERASED     = 1'b0,
        ST_PROGRAMMED = 1'b1
    } store_state_e;

    typedef enum logic [1:0] {
        EXT_FULL    = 2'b00,
        EXT_RESVD   = 2'b01,
        EXT_NOWRITE = 2'b10,
        EXT_OPEN    = 2'b11
    } ext_mode_e;
endpackage

// File: rtl/lock_store.sv
module lock_store
    import lockbit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_cmd,
    input  logic              prog_cmd,
    input  logic [LOCK_W-1:0] prog_data,
    output logic [LOCK_W-1:0] word_q,
    output logic              is_erased
);
    store_state_e state_q, state_d;
    logic [LOCK_W-1:0] word_d;
    logic [LOCK_W-1:0] merged;

    assign merged = word_q & (prog_data | PAD_MASK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ERASED;
            word_q  <= ERASED_WORD;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        word_d  = word_q;
        unique case (state_q)
            ST_ERASED: begin
                if (erase_cmd) begin
                    word_d = ERASED_WORD;
                end else if (prog_cmd) begin
                    word_d = merged;
                    if (merged != ERASED_WORD) state_d = ST_PROGRAMMED;
                end
            end
            ST_PROGRAMMED: begin
                if (erase_cmd) begin
                    word_d  = ERASED_WORD;
                    state_d = ST_ERASED;
                end else if (prog_cmd) begin
                    word_d = merged;
                end
            end
        endcase
    end

    always_comb begin
        is_erased = (state_q == ST_ERASED);
    end
endmodule

// File: rtl/ext_policy.sv
module ext_policy
    import lockbit_pkg::*;
(
    input  logic [1:0] seal,
    output logic       write_ok,
    output logic       verify_ok
);
    ext_mode_e mode;
    assign mode = ext_mode_e'(seal);

    always_comb begin
        unique case (mode)
            EXT_OPEN:    begin write_ok = 1'b1; verify_ok = 1'b1; end
            EXT_NOWRITE: begin write_ok = 1'b0; verify_ok = 1'b1; end
            EXT_RESVD:   begin write_ok = 1'b0; verify_ok = 1'b0; end
            EXT_FULL:    begin write_ok = 1'b0; verify_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sect_policy.sv
module sect_policy (
    input  logic wr_guard,
    input  logic rd_guard,
    output logic write_ok,
    output logic xread_ok
);
    always_comb begin
        unique case ({rd_guard, wr_guard})
            2'b11: begin write_ok = 1'b1; xread_ok = 1'b1; end
            2'b10: begin write_ok = 1'b0; xread_ok = 1'b1; end
            2'b00: begin write_ok = 1'b0; xread_ok = 1'b0; end
            2'b01: begin write_ok = 1'b1; xread_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/lockbit_guard.sv
module lockbit_guard
    import lockbit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_cmd,
    input  logic              prog_cmd,
    input  logic [LOCK_W-1:0] prog_data,
    input  logic              exec_sect,
    input  logic              tgt_sect,
    input  logic              vec_in_boot,
    input  logic              dbg_fuse_en,
    output logic [LOCK_W-1:0] lock_byte,
    output logic              ext_prog_ok,
    output logic              ext_verify_ok,
    output logic              fuse_write_ok,
    output logic              dbg_ok,
    output logic              spm_ok,
    output logic              lpm_ok,
    output logic              irq_ok,
    output logic              dbg_bypass
);
    logic             erased;
    logic             ext_wr;
    logic             ext_rd;
    logic [NSECT-1:0] wr_ok;
    logic [NSECT-1:0] xrd_ok;

    lock_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_cmd (erase_cmd),
        .prog_cmd  (prog_cmd),
        .prog_data (prog_data),
        .word_q    (lock_byte),
        .is_erased (erased)
    );

    ext_policy u_ext (
        .seal      (lock_byte[1:0]),
        .write_ok  (ext_wr),
        .verify_ok (ext_rd)
    );

    // section s uses bit 2+2s as write guard and 3+2s as cross-read guard
    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        sect_policy u_pol (
            .wr_guard (lock_byte[2 + 2*s]),
            .rd_guard (lock_byte[3 + 2*s]),
            .write_ok (wr_ok[s]),
            .xread_ok (xrd_ok[s])
        );
    end

    always_comb begin
        ext_prog_ok   = ext_wr;
        fuse_write_ok = ext_wr;
        dbg_ok        = ext_wr;
        ext_verify_ok = ext_rd;
        spm_ok        = wr_ok[tgt_sect];
        lpm_ok        = (exec_sect == tgt_sect) || xrd_ok[tgt_sect];
        irq_ok        = (exec_sect == vec_in_boot) || xrd_ok[exec_sect];
        dbg_bypass    = dbg_fuse_en && !erased;
    end
endmodule

// File: rtl/lockbit_guard_chk.sv
module lockbit_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       erase_cmd,
    input logic       prog_cmd,
    input logic [7:0] prog_data,
    input logic       exec_sect,
    input logic       tgt_sect,
    input logic       vec_in_boot,
    input logic       dbg_fuse_en,
    input logic [7:0] lock_byte,
    input logic       ext_prog_ok,
    input logic       fuse_write_ok,
    input logic       dbg_ok,
    input logic       lpm_ok,
    input logic       irq_ok,
    input logic       dbg_bypass
);
    p_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lock_byte[7:6] == 2'b11);

    p_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_cmd && !erase_cmd) |=> lock_byte == ($past(lock_byte) & ($past(prog_data) | 8'hC0)));

    p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_cmd |=> ((lock_byte & ~$past(lock_byte)) == 8'h00));

    p_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erase_cmd |=> lock_byte == 8'hFF);

    p_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_byte[1:0] != 2'b11) |-> !(ext_prog_ok || fuse_write_ok || dbg_ok));

    p_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_sect == tgt_sect) |-> lpm_ok);

    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_in_boot && !exec_sect && !lock_byte[3]) |-> !irq_ok);

    p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_byte == 8'hFF) |-> !dbg_bypass);
endmodule

bind lockbit_guard lockbit_guard_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .erase_cmd     (erase_cmd),
    .prog_cmd      (prog_cmd),
    .prog_data     (prog_data),
    .exec_sect     (exec_sect),
    .tgt_sect      (tgt_sect),
    .vec_in_boot   (vec_in_boot),
    .dbg_fuse_en   (dbg_fuse_en),
    .lock_byte     (lock_byte),
    .ext_prog_ok   (ext_prog_ok),
    .fuse_write_ok (fuse_write_ok),
    .dbg_ok        (dbg_ok),
    .lpm_ok        (lpm_ok),
    .irq_ok        (irq_ok),
    .dbg_bypass    (dbg_bypass)
);

// File: tb/tb_lockbit_guard.sv
`timescale 1ns/1ps
module tb_lockbit_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       erase_cmd = 1'b0;
    logic       prog_cmd = 1'b0;
    logic [7:0] prog_data = 8'hFF;
    logic       exec_sect = 1'b0;
    logic       tgt_sect = 1'b0;
    logic       vec_in_boot = 1'b0;
    logic       dbg_fuse_en = 1'b0;
    logic [7:0] lock_byte;
    logic       ext_prog_ok, ext_verify_ok, fuse_write_ok, dbg_ok;
    logic       spm_ok, lpm_ok, irq_ok, dbg_bypass;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lockbit_guard dut (
        .clk(clk), .rst_n(rst_n), .erase_cmd(erase_cmd), .prog_cmd(prog_cmd),
        .prog_data(prog_data), .exec_sect(exec_sect), .tgt_sect(tgt_sect),
        .vec_in_boot(vec_in_boot), .dbg_fuse_en(dbg_fuse_en), .lock_byte(lock_byte),
        .ext_prog_ok(ext_prog_ok), .ext_verify_ok(ext_verify_ok),
        .fuse_write_ok(fuse_write_ok), .dbg_ok(dbg_ok), .spm_ok(spm_ok),
        .lpm_ok(lpm_ok), .irq_ok(irq_ok), .dbg_bypass(dbg_bypass)
    );

    // vector: lock[17:12] exec[11] tgt[10] vib[9] fuse[8] expected[7:0]
    // expected bits: prog R5, verify R6, fuse R5, dbg R5, spm R7, lpm R8, irq R9, bypass R10
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        {6'b111111, 4'b0000, 8'b11111110},
        {6'b111110, 4'b0101, 8'b01001111},
        {6'b111101, 4'b1010, 8'b00001110},
        {6'b111011, 4'b1010, 8'b11110110},
        {6'b110011, 4'b1010, 8'b11110010},
        {6'b110111, 4'b0010, 8'b11111100},
        {6'b011111, 4'b0100, 8'b11111010},
        {6'b011111, 4'b1101, 8'b11111101},
        {6'b101111, 4'b1100, 8'b11110110},
        {6'b000000, 4'b0111, 8'b00000001}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_erase();
        @(negedge clk); erase_cmd = 1'b1;
        @(negedge clk); erase_cmd = 1'b0;
    endtask

    task automatic do_prog(input logic [7:0] d);
        @(negedge clk); prog_cmd = 1'b1; prog_data = d;
        @(negedge clk); prog_cmd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 lock_byte during reset", lock_byte, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 lock_byte after reset", lock_byte, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] v;
            logic [7:0]  g;
            v = VEC[i];
            do_erase();
            do_prog({2'b11, v[17:12]});
            exec_sect = v[11]; tgt_sect = v[10]; vec_in_boot = v[9]; dbg_fuse_en = v[8];
            #1;
            g = {ext_prog_ok, ext_verify_ok, fuse_write_ok, dbg_ok, spm_ok, lpm_ok, irq_ok, dbg_bypass};
            chk("R5 ext prog", {7'd0, g[7]}, {7'd0, v[7]});
            chk("R6 ext verify", {7'd0, g[6]}, {7'd0, v[6]});
            chk("R5 fuse/dbg", {6'd0, g[5:4]}, {6'd0, v[5:4]});
            chk("R7 spm", {7'd0, g[3]}, {7'd0, v[3]});
            chk("R8 lpm", {7'd0, g[2]}, {7'd0, v[2]});
            chk("R9 irq", {7'd0, g[1]}, {7'd0, v[1]});
            chk("R10 bypass", {7'd0, g[0]}, {7'd0, v[0]});
        end

        // R3: monotonic AND, update only after the edge
        do_erase();
        do_prog(8'hFC);
        chk("R3 first program", lock_byte, 8'hFC);
        @(negedge clk); prog_cmd = 1'b1; prog_data = 8'hF3;
        #1 chk("R3 unchanged in command cycle", lock_byte, 8'hFC);
        @(negedge clk); prog_cmd = 1'b0;
        chk("R3 AND result", lock_byte, 8'hF0);
        do_prog(8'hFF);
        chk("R3 ones do not restore", lock_byte, 8'hF0);
        do_prog(8'h3F);
        chk("R1 pad bits stay one", lock_byte, 8'hF0);

        // R4: erase, and erase beats program
        do_erase();
        chk("R4 erase", lock_byte, 8'hFF);
        do_prog(8'hC0);
        @(negedge clk); erase_cmd = 1'b1; prog_cmd = 1'b1; prog_data = 8'h00;
        @(negedge clk); erase_cmd = 1'b0; prog_cmd = 1'b0;
        chk("R4 erase wins over program", lock_byte, 8'hFF);
        dbg_fuse_en = 1'b1;
        #1 chk("R10 no bypass when erased", {7'd0, dbg_bypass}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule